// File: doc/BRIEF.md
# Serial Byte-Memory Target on a Two-Wire Bus

This block is an I2C target that puts a byte-wide storage array on the bus. It uses one address counter for every command, and that counter keeps its value from one transaction to the next. The array holds 2**ADDR_W bytes of 8 bits each. Setting ADDR_W to 14 gives 16384 bytes. A master selects the target with a 7-bit device address. The top four bits of that address are the fixed pattern 1010, and the low three bits must equal the `dev_sel` strap inputs.

A write-type transaction first sends an address high byte and then an address low byte. Those two bytes load the counter. Any data bytes that follow are stored one after another. While writing, the counter steps only inside the current page of 2**PAGE_W bytes.

A read-type transaction returns bytes starting at the counter. The master can load the counter first by sending a write-type header followed by a repeated START, which gives a random read. While reading, the counter walks the whole array and wraps from the top address to zero. The `wp` input, when high, blocks all changes to the array.

SCL and SDA are open-drain. The block sees each line as an input. For SDA it drives only a pull-low enable. Both bus lines are sampled with `clk`, so `clk` must run many times faster than SCL.

Top module: `i2c_mem_target`

## Requirements
- R1: The block acknowledges a device address byte whose top seven bits are 1010 followed by `dev_sel`, with R/W in bit 0. On any other device address it gives no ACK, and it ignores all bus traffic until the next START.
- R2: After a write-type device address, the block loads the counter from the next two bytes, high byte first. Address bits at or above ADDR_W are ignored. The block ACKs each address byte.
- R3: Data bytes after the address bytes are each ACKed and stored at successive counter values.
- R4: While writing, only the low PAGE_W counter bits advance, so a write past the page end wraps to the first byte of the same page.
- R5: A read-type device address with no address phase returns the byte at the counter, beginning right after the ACK.
- R6: A write-type header with two address bytes, followed by a repeated START and a read-type device address, returns the byte at the address that was sent.
- R7: While the master ACKs read bytes, the block keeps sending the byte at the next address. After a NoACK and a STOP it is idle with `sda_oe` low.
- R8: While reading, the counter wraps from 2**ADDR_W-1 to 0.
- R9: While `wp` is high, data bytes are still ACKed but the array is not changed.
- R10: After any read or write, the counter points one past the last byte accessed, with the page wrap applied for writes.
- R11: Reset releases SDA and clears the counter to 0. The array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and state clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Level seen on the SCL line |
| sda_i | input | 1 | Level seen on the SDA line |
| sda_oe | output | 1 | High pulls SDA low |
| wp | input | 1 | Write protect, high blocks array updates |
| dev_sel | input | 3 | Strap bits matched against the low device-address bits |

## Verification
The bench builds the block with ADDR_W = 10 and PAGE_W = 3, giving a 1024-byte array of 8-byte pages. With these values an 8-byte burst is enough to cross a page end on a write. The top-of-array wrap on a sequential read happens at 0x3FF. With two active bits in the high address byte, both the ignored high bits and the used high bits of that byte get exercised.

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       wp,
  input  logic [2:0] dev_sel
);
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} st_t;
  localparam logic [1:0] K_DEV = 2'd0, K_HI = 2'd1, K_LO = 2'd2, K_DAT = 2'd3;

  logic [2:0] scl_q, sda_q;
  st_t state;
  logic [1:0] kind;
  logic [3:0] cnt;
  logic [7:0] sr, hi;
  logic rd, mack;
  logic [ADDR_W-1:0] ptr;
  logic [7:0] mem [DEPTH];

  wire scl_n = scl_q[1], scl_p = scl_q[2];
  wire sda_n = sda_q[1], sda_p = sda_q[2];
  wire ev_start = scl_n & scl_p & sda_p & ~sda_n;
  wire ev_stop  = scl_n & scl_p & ~sda_p & sda_n;
  wire ev_rise  = scl_n & ~scl_p;
  wire ev_fall  = ~scl_n & scl_p;

  wire [15:0] full_addr = {hi, sr};
  wire [PAGE_W-1:0] pg_next = ptr[PAGE_W-1:0] + PAGE_W'(1);

  wire wr_evt  = ev_fall && state == S_RX && kind == K_DAT && cnt == 4'd8;
  wire tx_load = ev_fall && ((state == S_ACK && rd) || (state == S_MACK && mack));
  wire idle    = state == S_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk) begin
    if (wr_evt && !wp) mem[ptr] <= sr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      kind   <= K_DEV;
      cnt    <= '0;
      sr     <= '0;
      hi     <= '0;
      rd     <= 1'b0;
      mack   <= 1'b0;
      ptr    <= '0;
      sda_oe <= 1'b0;
    end else if (ev_start) begin
      state  <= S_RX;
      kind   <= K_DEV;
      cnt    <= '0;
      rd     <= 1'b0;
      sda_oe <= 1'b0;
    end else if (ev_stop) begin
      state  <= S_IDLE;
      sda_oe <= 1'b0;
    end else if (tx_load) begin
      state  <= S_TX;
      sr     <= mem[ptr];
      sda_oe <= ~mem[ptr][7];
      ptr    <= ptr + ADDR_W'(1);
      cnt    <= '0;
    end else begin
      case (state)
        S_RX: begin
          if (ev_rise) begin
            sr  <= {sr[6:0], sda_n};
            cnt <= cnt + 4'd1;
          end else if (ev_fall && cnt == 4'd8) begin
            cnt    <= '0;
            state  <= S_ACK;
            sda_oe <= 1'b1;
            case (kind)
              K_DEV: begin
                if (sr[7:1] == {4'b1010, dev_sel}) begin
                  rd   <= sr[0];
                  kind <= K_HI;
                end else begin
                  state  <= S_IDLE;
                  sda_oe <= 1'b0;
                end
              end
              K_HI: begin
                hi   <= sr;
                kind <= K_LO;
              end
              K_LO: begin
                ptr  <= full_addr[ADDR_W-1:0];
                kind <= K_DAT;
              end
              default: ptr <= {ptr[ADDR_W-1:PAGE_W], pg_next};
            endcase
          end
        end
        S_ACK: begin
          if (ev_fall) begin
            sda_oe <= 1'b0;
            state  <= S_RX;
          end
        end
        S_TX: begin
          if (ev_rise) cnt <= cnt + 4'd1;
          else if (ev_fall) begin
            if (cnt == 4'd8) begin
              state  <= S_MACK;
              sda_oe <= 1'b0;
            end else begin
              sr     <= {sr[6:0], 1'b0};
              sda_oe <= ~sr[6];
            end
          end
        end
        S_MACK: begin
          if (ev_rise) mack <= ~sda_n;
          else if (ev_fall) state <= S_IDLE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              idle,
  input logic              wr_evt,
  input logic              tx_load,
  input logic [ADDR_W-1:0] ptr
);
  p_sda_change_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  p_idle_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_oe);

  p_page_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));

  p_read_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> ptr == ADDR_W'($past(ptr) + 1));
endmodule

bind i2c_mem_target i2c_mem_target_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .idle(idle),
  .wr_evt(wr_evt), .tx_load(tx_load), .ptr(ptr)
);

// File: tb/tb_i2c_mem_target.sv
module tb_i2c_mem_target;
  localparam int AW = 10;
  localparam int PW = 3;
  localparam logic [6:0] DEV = 7'b1010101;

  logic clk = 0, rst_n = 0, m_scl = 1, m_low = 0, wp = 0;
  logic sda_oe;
  wire sda_line = ~(m_low | sda_oe);
  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  i2c_mem_target #(.ADDR_W(AW), .PAGE_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .wp(wp), .dev_sel(3'b101)
  );

  localparam logic [23:0] VEC [6] = '{
    {16'h0005, 8'hA5}, {16'h0133, 8'h3C}, {16'hFE40, 8'h81},
    {16'h03FF, 8'h7E}, {16'h8200, 8'h11}, {16'h0011, 8'hC4}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    wait_n(5); m_low = ~b; wait_n(5);
    m_scl = 1; wait_n(5); s = sda_line; wait_n(5);
    m_scl = 0;
  endtask

  task automatic bus_start();
    wait_n(5); m_low = 0; wait_n(5);
    m_scl = 1; wait_n(10); m_low = 1; wait_n(10);
    m_scl = 0;
  endtask

  task automatic bus_stop();
    wait_n(5); m_low = 1; wait_n(5);
    m_scl = 1; wait_n(10); m_low = 0; wait_n(10);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] d);
    logic s;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      d = {d[6:0], s};
    end
    clk_bit(~give_ack, s);
  endtask

  task automatic addr_phase(input logic [15:0] a, output logic ok);
    logic a0, a1, a2;
    bus_start();
    wr_byte({DEV, 1'b0}, a0);
    wr_byte(a[15:8], a1);
    wr_byte(a[7:0], a2);
    ok = a0 & a1 & a2;
  endtask

  task automatic rand_read(input logic [15:0] a, output logic [7:0] d);
    logic ok, ak;
    addr_phase(a, ok);
    bus_start();
    wr_byte({DEV, 1'b1}, ak);
    rd_byte(1'b0, d);
    bus_stop();
  endtask

  task automatic cur_read(output logic [7:0] d);
    logic ak;
    bus_start();
    wr_byte({DEV, 1'b1}, ak);
    rd_byte(1'b0, d);
    bus_stop();
  endtask

  initial begin
    wait_n(200000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic ok, ak, a2;
    logic [7:0] d;
    wait_n(4); rst_n = 1; wait_n(4);
    chk("R11 sda released after reset", 16'(sda_oe), 16'h0);

    // R3 two bytes at 0, then reset and read at counter 0 (R11)
    addr_phase(16'h0000, ok);
    wr_byte(8'h5A, ak); wr_byte(8'h99, a2);
    bus_stop();
    chk("R3 two-byte write acks", 16'({ok, ak, a2}), 16'h7);
    rst_n = 0; wait_n(4); rst_n = 1; wait_n(4);
    cur_read(d);
    chk("R11 counter cleared by reset", 16'(d), 16'h5A);

    // R2/R6 vector table: byte writes, then random reads
    for (int i = 0; i < 6; i++) begin
      addr_phase(VEC[i][23:8], ok);
      wr_byte(VEC[i][7:0], ak);
      bus_stop();
      chk("R2 byte write acks", 16'({ok, ak}), 16'h3);
    end
    for (int i = 0; i < 6; i++) begin
      rand_read(VEC[i][23:8], d);
      chk("R6 random read data", 16'(d), 16'(VEC[i][7:0]));
    end

    // R1 address mismatch: no ACK, later bytes ignored
    bus_start();
    wr_byte({7'b1010011, 1'b0}, ak);
    chk("R1 no ACK on select mismatch", 16'(ak), 16'h0);
    wr_byte(8'h00, ak); wr_byte(8'h05, a2);
    chk("R1 bytes ignored after mismatch", 16'({ak, a2}), 16'h0);
    wr_byte(8'hEE, ak);
    bus_stop();
    bus_start();
    wr_byte({7'b0110101, 1'b0}, ak);
    bus_stop();
    chk("R1 no ACK on wrong fixed bits", 16'(ak), 16'h0);
    rand_read(16'h0005, d);
    chk("R1 array untouched after mismatch", 16'(d), 16'hA5);

    // R4 page write of 8 bytes from 0x0A5 wraps inside page 0x0A0..0x0A7
    addr_phase(16'h00A5, ok);
    a2 = 1;
    for (int i = 0; i < 8; i++) begin
      wr_byte(8'h10 + 8'(i), ak);
      a2 &= ak;
    end
    bus_stop();
    chk("R3 page write acks", 16'({ok, a2}), 16'h3);
    cur_read(d);
    chk("R10 counter one past last write, page-wrapped", 16'(d), 16'h10);
    rand_read(16'h00A0, d);
    chk("R4 wrapped byte at page start", 16'(d), 16'h13);
    rand_read(16'h00A4, d);
    chk("R4 last wrapped byte", 16'(d), 16'h17);

    // R7 sequential read across the page
    addr_phase(16'h00A0, ok);
    bus_start();
    wr_byte({DEV, 1'b1}, ak);
    for (int i = 0; i < 8; i++) begin
      rd_byte(i != 7, d);
      chk("R7 sequential read byte", 16'(d), 16'(8'h10 + 8'((i + 3) % 8)));
    end
    bus_stop();
    wait_n(6);
    chk("R7 SDA released after NoACK and STOP", 16'(sda_oe), 16'h0);

    // R8 read wrap at top of array
    addr_phase(16'h03FF, ok);
    bus_start();
    wr_byte({DEV, 1'b1}, ak);
    rd_byte(1'b1, d);
    chk("R8 top byte", 16'(d), 16'h7E);
    rd_byte(1'b0, d);
    bus_stop();
    chk("R8 wrap to address 0", 16'(d), 16'h5A);
    cur_read(d);
    chk("R5 current read after wrap", 16'(d), 16'h99);

    // R9 write protect
    wp = 1;
    addr_phase(16'h0133, ok);
    wr_byte(8'hFF, ak);
    bus_stop();
    wp = 0;
    chk("R9 data still acked under wp", 16'({ok, ak}), 16'h3);
    rand_read(16'h0133, d);
    chk("R9 array unchanged under wp", 16'(d), 16'h3C);

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule